// File: doc/BRIEF.md
# Gated High-Time Pulse Width Timer

This block measures how many clock cycles an input signal spends high. The input passes through a synchronizer of two flops. An edge detector runs on the synchronized level. Each clock cycle is one tick of the measurement. The timer arms only after it sees a falling edge, so every measurement starts from a low level. A high phase that is already in progress when reset ends is never measured. The counter then runs through the next high phase and stops at the falling edge that ends it. At that edge the result is latched and a valid strobe pulses for one cycle. The same falling edge arms the next measurement at once.

The tick counter has CNT_W bits and is extended by an overflow counter. The true width is therefore `ovf_cnt_o * 2^CNT_W + width_o`. The overflow counter saturates at all ones instead of wrapping, and it raises a sticky error flag when that happens. Two elaboration-time options widen the use of the block. NUM_PULSES = M makes the block sum M consecutive high times and report the sum once, together with the number of pulses it covers, so that the host can form an average. PERIOD_MODE = 1 makes the block count every cycle once it is armed, so the result is the time spanned by M whole input periods between falling edges.

The controller is a small state machine with three states:
- ST_IDLE waits for the first falling edge (transition arm).
- ST_MEASURE counts. At each falling edge it either bumps the pulse count (transition next_pulse) or, on the M-th edge, latches the result and clears the counters (transition latch).
- ST_REPORT drives the valid strobe for one cycle and keeps counting. It always returns to ST_MEASURE (transition resume).

Top module: `pulse_width_timer`

## Requirements
- R1: After reset, valid_o, width_o, ovf_cnt_o, pulses_o and ovf_err_o are all 0. Nothing is measured before the first falling edge of the synchronized input, so a high level present at reset release produces no result.
- R2: With PERIOD_MODE = 0, the reported width counts exactly the clock cycles in which the input was high. width_o holds that count modulo 2^CNT_W.
- R3: Each time the CNT_W-bit tick counter wraps, ovf_cnt_o for that measurement goes up by one, so the width equals ovf_cnt_o * 2^CNT_W + width_o.
- R4: Once the overflow count is all ones, a further wrap leaves it at all ones and sets ovf_err_o. ovf_err_o stays at 1 until reset, while the low word keeps wrapping modulo 2^CNT_W.
- R5: valid_o is high for exactly one clock per completed measurement. It rises on the third rising clock edge after the input pin falls.
- R6: The falling edge that ends a measurement also starts the next one from zero. Back-to-back pulses separated by a single low cycle are each reported.
- R7: With NUM_PULSES = M, the block reports once after the M-th falling edge. The result is the sum of the M high times, with pulses_o equal to M. No valid strobe occurs for the earlier edges.
- R8: With PERIOD_MODE = 1, every clock cycle from the arming falling edge onward is counted. The result is the number of cycles spanned by M input periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | 1 | Asynchronous signal whose high time is measured |
| width_o | output | CNT_W | Low word of the latched width or sum |
| ovf_cnt_o | output | OVF_W | Number of tick-counter wraps in the latched result |
| pulses_o | output | PC_W | Number of pulses covered by the latched result |
| valid_o | output | 1 | One-cycle strobe when a new result is presented |
| ovf_err_o | output | 1 | Sticky flag: the overflow count saturated |

## Verification
A small single-pulse instance is swept through every high time from 1 to 40 cycles. This range separates plain counts from counts that cross one or two wraps of a 4-bit tick counter. A 70-cycle pulse then drives the overflow count past all ones, which separates saturation from wrapping. A later short pulse shows that the error flag stays set. A high level held across reset release must produce no result, and a run of pulses with one-cycle gaps must yield one strobe per pulse. A three-pulse accumulating instance is driven with a grid of pulse-length triples, which shows that only the third edge reports and that the reported value is the sum. A period-mode instance is driven with square waves of several high times, which checks that low cycles are counted too.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_MEASURE = 2'd1,
        ST_REPORT  = 2'd2
    } pwt_state_e;

endpackage

// File: rtl/pwt_sync_edge.sv
module pwt_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level_o,
    output logic fall_o
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign level_o = sync_q[STAGES-1];
    assign fall_o  = prev_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/pwt_counter.sv
module pwt_counter #(
    parameter int CNT_W = 16,
    parameter int OVF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt_nx,
    output logic [OVF_W-1:0] ovf_nx,
    output logic             err_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [OVF_W-1:0] OVF_MAX = {OVF_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [OVF_W-1:0] ovf_q;
    logic             err_q;
    logic             wrap;
    logic             err_nx;

    always_comb begin
        wrap   = inc && (cnt_q == CNT_MAX);
        cnt_nx = cnt_q + CNT_W'(inc);
        ovf_nx = ovf_q;
        err_nx = err_q;
        if (wrap) begin
            if (ovf_q == OVF_MAX) begin
                err_nx = 1'b1;
            end else begin
                ovf_nx = ovf_q + OVF_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= '0;
            err_q <= 1'b0;
        end else begin
            cnt_q <= clr ? '0 : cnt_nx;
            ovf_q <= clr ? '0 : ovf_nx;
            err_q <= err_nx;
        end
    end

    assign err_o = err_q;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q); // R4
    AST_OVF_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q == OVF_MAX && !clr) |=> (ovf_q == OVF_MAX)); // R4
    AST_CLR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0 && ovf_q == '0)); // R6

endmodule

// File: rtl/pwt_ctrl.sv
module pwt_ctrl
    import pwt_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int OVF_W      = 8,
    parameter int NUM_PULSES = 1,
    parameter int PC_W       = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall,
    input  logic [CNT_W-1:0] cnt_nx,
    input  logic [OVF_W-1:0] ovf_nx,
    output logic             measuring_o,
    output logic             clr_o,
    output logic             valid_o,
    output logic [CNT_W-1:0] width_o,
    output logic [OVF_W-1:0] ovf_o,
    output logic [PC_W-1:0]  pulses_o
);

    localparam logic [PC_W-1:0] LAST_IDX = PC_W'(NUM_PULSES - 1);

    pwt_state_e      state_q, state_d;
    logic [PC_W-1:0] pulses_q, pulses_d;
    logic            latch;

    always_comb begin
        state_d  = state_q;
        pulses_d = pulses_q;
        latch    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (fall) state_d = ST_MEASURE;
            end
            ST_MEASURE: begin
                if (fall) begin
                    if (pulses_q == LAST_IDX) begin
                        latch    = 1'b1;
                        pulses_d = '0;
                        state_d  = ST_REPORT;
                    end else begin
                        pulses_d = pulses_q + PC_W'(1);
                    end
                end
            end
            ST_REPORT: begin
                state_d = ST_MEASURE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            pulses_q <= '0;
        end else begin
            state_q  <= state_d;
            pulses_q <= pulses_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width_o  <= '0;
            ovf_o    <= '0;
            pulses_o <= '0;
        end else if (latch) begin
            width_o  <= cnt_nx;
            ovf_o    <= ovf_nx;
            pulses_o <= pulses_q + PC_W'(1);
        end
    end

    assign measuring_o = (state_q != ST_IDLE);
    assign clr_o       = latch;
    assign valid_o     = (state_q == ST_REPORT);

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R5
    AST_VALID_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(fall)); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !fall) |=> (state_q == ST_IDLE)); // R1
    AST_PULSE_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        pulses_q <= LAST_IDX); // R7

endmodule

// File: rtl/pulse_width_timer.sv
module pulse_width_timer #(
    parameter int  CNT_W       = 16,
    parameter int  OVF_W       = 8,
    parameter int  NUM_PULSES  = 1,
    parameter bit  PERIOD_MODE = 1'b0,
    localparam int PC_W        = $clog2(NUM_PULSES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_in,
    output logic [CNT_W-1:0] width_o,
    output logic [OVF_W-1:0] ovf_cnt_o,
    output logic [PC_W-1:0]  pulses_o,
    output logic             valid_o,
    output logic             ovf_err_o
);

    logic             level;
    logic             fall;
    logic             gate;
    logic             measuring;
    logic             clr;
    logic [CNT_W-1:0] cnt_nx;
    logic [OVF_W-1:0] ovf_nx;

    pwt_sync_edge #(.STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (pulse_in),
        .level_o (level),
        .fall_o  (fall)
    );

    generate
        if (PERIOD_MODE) begin : g_period
            assign gate = 1'b1;
        end else begin : g_high
            assign gate = level;
        end
    endgenerate

    pwt_counter #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (measuring & gate),
        .clr    (clr),
        .cnt_nx (cnt_nx),
        .ovf_nx (ovf_nx),
        .err_o  (ovf_err_o)
    );

    pwt_ctrl #(
        .CNT_W      (CNT_W),
        .OVF_W      (OVF_W),
        .NUM_PULSES (NUM_PULSES),
        .PC_W       (PC_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .fall        (fall),
        .cnt_nx      (cnt_nx),
        .ovf_nx      (ovf_nx),
        .measuring_o (measuring),
        .clr_o       (clr),
        .valid_o     (valid_o),
        .width_o     (width_o),
        .ovf_o       (ovf_cnt_o),
        .pulses_o    (pulses_o)
    );

endmodule

// File: tb/pulse_width_timer_tb_top.sv
`timescale 1ns/100ps
module pulse_width_timer_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_a = 1'b1;
    logic pin_b = 1'b0;
    logic pin_c = 1'b0;

    always #2.5 clk = ~clk;

    logic [3:0] w_a;  logic [1:0] o_a;  logic       p_a;  logic v_a, e_a;
    logic [7:0] w_b;  logic [1:0] o_b;  logic [1:0] p_b;  logic v_b, e_b;
    logic [7:0] w_c;  logic [1:0] o_c;  logic [1:0] p_c;  logic v_c, e_c;

    pulse_width_timer #(.CNT_W(4), .OVF_W(2), .NUM_PULSES(1), .PERIOD_MODE(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .pulse_in(pin_a), .width_o(w_a), .ovf_cnt_o(o_a),
        .pulses_o(p_a), .valid_o(v_a), .ovf_err_o(e_a));

    pulse_width_timer #(.CNT_W(8), .OVF_W(2), .NUM_PULSES(3), .PERIOD_MODE(1'b0)) dut_acc_i (
        .clk(clk), .rst_n(rst_n), .pulse_in(pin_b), .width_o(w_b), .ovf_cnt_o(o_b),
        .pulses_o(p_b), .valid_o(v_b), .ovf_err_o(e_b));

    pulse_width_timer #(.CNT_W(8), .OVF_W(2), .NUM_PULSES(2), .PERIOD_MODE(1'b1)) dut_per_i (
        .clk(clk), .rst_n(rst_n), .pulse_in(pin_c), .width_o(w_c), .ovf_cnt_o(o_c),
        .pulses_o(p_c), .valid_o(v_c), .ovf_err_o(e_c));

    int n_a = 0, n_b = 0, n_c = 0;
    int cw_a, co_a, ce_a, cw_b, cp_b, cw_c, cp_c;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always @(negedge clk) begin
        if (v_a) begin n_a <= n_a + 1; cw_a <= int'(w_a); co_a <= int'(o_a); ce_a <= int'(e_a); end
        if (v_b) begin n_b <= n_b + 1; cw_b <= int'(w_b); cp_b <= int'(p_b); end
        if (v_c) begin n_c <= n_c + 1; cw_c <= int'(w_c); cp_c <= int'(p_c); end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drv(input int which, input logic v, input int n);
        case (which)
            0: pin_a = v;
            1: pin_b = v;
            default: pin_c = v;
        endcase
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #1;
        chk("R1 reset valid", int'(v_a), 0);
        chk("R1 reset width", int'(w_a), 0);
        chk("R1 reset err", int'(e_a), 0);
        chk("R1 reset pulses", int'(p_b), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: high level at reset release is never measured
        drv(0, 1'b1, 6);
        drv(0, 1'b0, 6);
        #1;
        chk("R1 no result before arming", n_a, 0);

        // R2 R3 R5: sweep of high times across counter wraps
        for (int h = 1; h <= 40; h++) begin
            n_a = 0;
            drv(0, 1'b1, h);
            drv(0, 1'b0, 6);
            #1;
            chk("R5 one strobe", n_a, 1);
            chk("R2 width low word", cw_a, h % 16);
            chk("R3 overflow count", co_a, h / 16);
        end
        chk("R4 no error yet", int'(e_a), 0);

        // R4: saturation
        n_a = 0;
        drv(0, 1'b1, 70);
        drv(0, 1'b0, 6);
        #1;
        chk("R4 saturated count", co_a, 3);
        chk("R4 low word wraps", cw_a, 70 % 16);
        chk("R4 error set", ce_a, 1);
        n_a = 0;
        drv(0, 1'b1, 5);
        drv(0, 1'b0, 6);
        #1;
        chk("R4 error sticky", ce_a, 1);
        chk("R6 fresh width", cw_a, 5);
        chk("R6 fresh overflow", co_a, 0);

        // R6: one-cycle low gaps
        n_a = 0;
        for (int k = 0; k < 3; k++) begin
            drv(0, 1'b1, 3);
            drv(0, 1'b0, 1);
        end
        drv(0, 1'b0, 6);
        #1;
        chk("R6 back-to-back strobes", n_a, 3);
        chk("R6 back-to-back width", cw_a, 3);

        // R7: three-pulse accumulation
        drv(1, 1'b1, 3);
        drv(1, 1'b0, 4);
        #1;
        chk("R7 arm no result", n_b, 0);
        for (int a = 1; a <= 4; a++) begin
            for (int b = 1; b <= 4; b++) begin
                n_b = 0;
                drv(1, 1'b1, a);
                drv(1, 1'b0, 2);
                drv(1, 1'b1, b);
                drv(1, 1'b0, 2);
                drv(1, 1'b1, a + b);
                #1;
                chk("R7 no early strobe", n_b, 0);
                drv(1, 1'b0, 6);
                #1;
                chk("R7 one strobe", n_b, 1);
                chk("R7 sum", cw_b, 2 * (a + b));
                chk("R7 pulse count", cp_b, 3);
            end
        end

        // R8: period mode over two periods
        drv(2, 1'b1, 3);
        drv(2, 1'b0, 4);
        for (int h = 1; h <= 12; h++) begin
            n_c = 0;
            drv(2, 1'b1, h);
            drv(2, 1'b0, 4);
            drv(2, 1'b1, h);
            drv(2, 1'b0, 4);
            #1;
            chk("R8 one strobe", n_c, 1);
            chk("R8 span of two periods", cw_c, 2 * (h + 4));
            chk("R8 period count", cp_c, 2);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R5 actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

endmodule